// File: doc/BRIEF.md
# Page Frame Replacement Tracker

This block models the resident set of a small paged memory. A fixed number of physical frames each hold one virtual page number. The block takes a stream of page references, one per strobe. For each reference it reports whether the page was already resident (a hit) or not (a fault).

On a fault the block places the page in the lowest-numbered empty frame if one exists. Otherwise it displaces a victim frame and reports which page was pushed out. The victim choice is fixed at build time by a policy parameter:

- First-in-first-out picks the frame whose page was loaded longest ago.
- Least-recently-used picks the frame whose page was referenced longest ago.

A saturating counter totals the faults since reset. Moving pages to and from backing storage and keeping the page table are left to the surrounding logic, which acts on the reported frame index and evicted page.

Top module: `page_repl_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every frame becomes empty, `fault_count` becomes 0 and `resp_valid` becomes 0. The first reference after reset is therefore always a fault into frame 0.
- R2: A reference presented with `ref_valid` high at a rising edge is answered by registered outputs with `resp_valid` high in the following cycle. `resp_valid` is low in any cycle after an edge where `ref_valid` was low. Strobes may arrive on back-to-back cycles.
- R3: A reference to a resident page gives `resp_fault`=0 and `resp_evict_valid`=0, and `resp_frame` equals the index of the frame holding that page.
- R4: A fault while at least one frame is empty loads the page into the lowest-indexed empty frame, reports that index in `resp_frame`, and gives `resp_evict_valid`=0.
- R5: With POLICY set to FIFO, a fault with all frames full replaces the frame whose current page was loaded earliest. Hits do not change this order.
- R6: With POLICY set to LRU, a fault with all frames full replaces the frame whose page was least recently referenced. A hit counts as a reference, as does a load.
- R7: `fault_count` rises by exactly one for each fault and is unchanged by hits and idle cycles. It saturates at 2^CNT_W-1.
- R8: When a fault replaces a resident page, `resp_evict_valid`=1 and `resp_evict_page` carries the displaced page number. `resp_evict_valid` is never 1 without `resp_fault`.
- R9: With 3 frames, the reference string 7,0,1,2,0,3,0,4,2,3,0,3,0,3,2,1,2,0,1,7,0,1 applied from reset ends with `fault_count` 15 under FIFO and 12 under LRU.
- R10: Under FIFO, the string 1,2,3,4,1,2,5,1,2,3,4,5 applied from reset yields 9 faults with 3 frames and 10 faults with 4 frames.
- R11: In cycles following an edge with `ref_valid` low, `resp_fault`, `resp_frame`, `resp_evict_valid`, `resp_evict_page` and `fault_count` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | Strobe: `ref_page` holds a reference this cycle |
| ref_page | input | PAGE_W | Virtual page number being referenced |
| resp_valid | output | 1 | Response fields describe the previous cycle's reference |
| resp_fault | output | 1 | 1 = page was not resident |
| resp_frame | output | IDX_W | Frame that holds the page after the reference |
| resp_evict_valid | output | 1 | 1 = a resident page was displaced |
| resp_evict_page | output | PAGE_W | Page number that was displaced |
| fault_count | output | CNT_W | Saturating number of faults since reset |

## Verification
Three instances run on the same reference stream: FIFO with 3 frames, LRU with 3 frames and FIFO with 4 frames.

A short string that re-touches the oldest page before a fault separates the two policies, because FIFO and LRU evict different frames on it. The 22-reference string checks the policies against known fault totals. The Belady string shows that the 4-frame FIFO faults more often than the 3-frame one. A run of distinct pages drives the narrow counter into saturation, while idle gaps and a mid-run reset show that the outputs hold and that residency is forgotten.

// File: rtl/pgr_pkg.sv
// Package: shared types and helpers for the page replacement tracker.
// Assumes: nothing beyond standard constant-function evaluation.
package pgr_pkg;

    // Victim selection policy chosen at build time.
    typedef enum logic {
        POLICY_FIFO = 1'b0,
        POLICY_LRU  = 1'b1
    } repl_policy_e;

    // Width of an index able to address n items (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pgr_lookup.sv
// Module: pgr_lookup
// Purely combinational search of the frame table. It reports whether the
// page is resident and where, and which empty frame has the lowest index.
// Assumes: a resident page lives in at most one frame (the tracker never
// loads a page that is already resident).
module pgr_lookup #(
    parameter int NUM_FRAMES = 3,
    parameter int PAGE_W     = 8,
    parameter int IDX_W      = 2
) (
    input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] frame_pages,
    input  logic [NUM_FRAMES-1:0]             frame_used,
    input  logic [PAGE_W-1:0]                 probe_page,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx,
    output logic                              any_free,
    output logic [IDX_W-1:0]                  free_idx
);

    logic [NUM_FRAMES-1:0] match_vec;

    // One comparator per frame, gated by its occupancy bit.
    genvar g;
    generate
        for (g = 0; g < NUM_FRAMES; g++) begin : g_cmp
            assign match_vec[g] = frame_used[g] && (frame_pages[g] == probe_page);
        end
    endgenerate

    // Lowest-index encoder for the match vector.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // Lowest-index encoder for empty frames.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (!frame_used[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pgr_rank_keeper.sv
// Module: pgr_rank_keeper
// Keeps an age rank per frame: 0 is the most recently touched frame, and
// higher ranks are older. Touching a frame moves it to rank 0 and ages every
// occupied frame that was younger than it by one. The victim is the frame
// holding rank NUM_FRAMES-1.
// Assumes: touch_fill is set only when the touched frame was empty. The
// victim output is meaningful only when every frame is occupied, because
// only then do the ranks form a full permutation.
module pgr_rank_keeper #(
    parameter int NUM_FRAMES = 3,
    parameter int IDX_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  touch_en,
    input  logic [IDX_W-1:0]      touch_idx,
    input  logic                  touch_fill,
    input  logic [NUM_FRAMES-1:0] frame_used,
    output logic [IDX_W-1:0]      victim_idx
);

    localparam int RW = $clog2(NUM_FRAMES + 1);

    logic [NUM_FRAMES-1:0][RW-1:0] rank_q;
    logic [RW-1:0]                 touch_rank;

    // Rank of the touched frame; an empty frame counts as older than all.
    always_comb begin
        touch_rank = touch_fill ? RW'(NUM_FRAMES) : rank_q[touch_idx];
    end

    // One rank register per frame, updated on every touch.
    genvar g;
    generate
        for (g = 0; g < NUM_FRAMES; g++) begin : g_rank
            // Move to the front if touched, or age by one if younger than the touched frame.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rank_q[g] <= '0;
                end else if (touch_en) begin
                    if (touch_idx == IDX_W'(g)) begin
                        rank_q[g] <= '0;
                    end else if (frame_used[g] && (rank_q[g] < touch_rank)) begin
                        rank_q[g] <= rank_q[g] + RW'(1);
                    end
                end
            end
        end
    endgenerate

    // Find the frame holding the oldest rank.
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (rank_q[i] == RW'(NUM_FRAMES - 1)) begin
                victim_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pgr_fault_counter.sv
// Module: pgr_fault_counter
// Saturating up-counter of page faults.
// Assumes: bump is high for one cycle per fault.
module pgr_fault_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count faults, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && (count != CNT_MAX)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/page_repl_tracker.sv
// Module: page_repl_tracker (top)
// Tracks which virtual pages occupy NUM_FRAMES physical frames, classifies
// each reference as a hit or a fault, places faulting pages (empty frame
// first, otherwise a FIFO or LRU victim) and counts faults. The response is
// registered and appears in the cycle after the strobe.
// Assumes: one reference per cycle at most; the caller performs any data
// movement implied by the response.
module page_repl_tracker
    import pgr_pkg::*;
#(
    parameter int           NUM_FRAMES = 3,
    parameter int           PAGE_W     = 8,
    parameter int           CNT_W      = 16,
    parameter repl_policy_e POLICY     = POLICY_FIFO,
    localparam int          IDX_W      = idx_width(NUM_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_valid,
    input  logic [PAGE_W-1:0] ref_page,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [IDX_W-1:0]  resp_frame,
    output logic              resp_evict_valid,
    output logic [PAGE_W-1:0] resp_evict_page,
    output logic [CNT_W-1:0]  fault_count
);

    logic [NUM_FRAMES-1:0][PAGE_W-1:0] page_q;
    logic [NUM_FRAMES-1:0]             used_q;

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] victim_idx;
    logic [IDX_W-1:0] load_idx;
    logic             fault;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic             touch_fill;

    pgr_lookup #(
        .NUM_FRAMES (NUM_FRAMES),
        .PAGE_W     (PAGE_W),
        .IDX_W      (IDX_W)
    ) u_lookup (
        .frame_pages (page_q),
        .frame_used  (used_q),
        .probe_page  (ref_page),
        .hit         (hit),
        .hit_idx     (hit_idx),
        .any_free    (any_free),
        .free_idx    (free_idx)
    );

    // Fault classification and placement target.
    always_comb begin
        fault      = ref_valid && !hit;
        load_idx   = any_free ? free_idx : victim_idx;
        touch_fill = fault && any_free;
    end

    // Policy variant: which events refresh a frame's age.
    generate
        if (POLICY == POLICY_LRU) begin : g_lru
            assign touch_en  = ref_valid;
            assign touch_idx = hit ? hit_idx : load_idx;
        end else begin : g_fifo
            assign touch_en  = fault;
            assign touch_idx = load_idx;
        end
    endgenerate

    pgr_rank_keeper #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_ranks (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .touch_fill (touch_fill),
        .frame_used (used_q),
        .victim_idx (victim_idx)
    );

    pgr_fault_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (fault),
        .count (fault_count)
    );

    // Frame table: load the faulting page into its chosen frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
            page_q <= '0;
        end else if (fault) begin
            used_q[load_idx] <= 1'b1;
            page_q[load_idx] <= ref_page;
        end
    end

    // Registered response, held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid       <= 1'b0;
            resp_fault       <= 1'b0;
            resp_frame       <= '0;
            resp_evict_valid <= 1'b0;
            resp_evict_page  <= '0;
        end else begin
            resp_valid <= ref_valid;
            if (ref_valid) begin
                resp_fault       <= !hit;
                resp_frame       <= hit ? hit_idx : load_idx;
                resp_evict_valid <= !hit && !any_free;
                resp_evict_page  <= (!hit && !any_free) ? page_q[victim_idx] : '0;
            end
        end
    end

endmodule

// File: rtl/pgr_checker.sv
// Module: pgr_checker
// Temporal checks on the tracker's ports, attached to every instance by bind.
// Assumes: synchronous active-low reset; checks that look back one cycle
// are armed only after one clean cycle out of reset.
module pgr_checker #(
    parameter int NUM_FRAMES = 3,
    parameter int PAGE_W     = 8,
    parameter int CNT_W      = 16,
    parameter int IDX_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_valid,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [IDX_W-1:0]  resp_frame,
    input logic              resp_evict_valid,
    input logic [PAGE_W-1:0] resp_evict_page,
    input logic [CNT_W-1:0]  fault_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic armed;

    // Arm the look-back checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> resp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |=> !resp_valid);

    a_r3_hit_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> !resp_evict_valid);

    a_r8_evict_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
        resp_evict_valid |-> resp_fault);

    a_r4_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (int'(resp_frame) < NUM_FRAMES));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (resp_valid && resp_fault && ($past(fault_count) != CNT_MAX))
            |-> (fault_count == $past(fault_count) + CNT_W'(1)));

    a_r7_count_still: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !(resp_valid && resp_fault) |-> $stable(fault_count));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !resp_valid |-> ($stable(resp_fault) && $stable(resp_frame)
                         && $stable(resp_evict_valid) && $stable(resp_evict_page)));

endmodule

bind page_repl_tracker pgr_checker #(
    .NUM_FRAMES (NUM_FRAMES),
    .PAGE_W     (PAGE_W),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
) u_pgr_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .ref_valid        (ref_valid),
    .resp_valid       (resp_valid),
    .resp_fault       (resp_fault),
    .resp_frame       (resp_frame),
    .resp_evict_valid (resp_evict_valid),
    .resp_evict_page  (resp_evict_page),
    .fault_count      (fault_count)
);

// File: tb/page_repl_tracker_test.sv
`timescale 1ns/1ps
module page_repl_tracker_test;
    import pgr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_valid = 1'b0;
    logic [7:0] ref_page = '0;

    always #10 clk = ~clk;

    // Instance 0: FIFO, 3 frames. Instance 1: LRU, 3 frames. Instance 2: FIFO, 4 frames, 4-bit counter.
    logic       v0, f0, e0; logic [1:0] fr0; logic [7:0] p0; logic [7:0]  c0;
    logic       v1, f1, e1; logic [1:0] fr1; logic [7:0] p1; logic [7:0]  c1;
    logic       v2, f2, e2; logic [1:0] fr2; logic [7:0] p2; logic [3:0]  c2;

    page_repl_tracker #(.NUM_FRAMES(3), .PAGE_W(8), .CNT_W(8), .POLICY(POLICY_FIFO)) uut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
        .resp_valid(v0), .resp_fault(f0), .resp_frame(fr0),
        .resp_evict_valid(e0), .resp_evict_page(p0), .fault_count(c0));

    page_repl_tracker #(.NUM_FRAMES(3), .PAGE_W(8), .CNT_W(8), .POLICY(POLICY_LRU)) uut_lru (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
        .resp_valid(v1), .resp_fault(f1), .resp_frame(fr1),
        .resp_evict_valid(e1), .resp_evict_page(p1), .fault_count(c1));

    page_repl_tracker #(.NUM_FRAMES(4), .PAGE_W(8), .CNT_W(4), .POLICY(POLICY_FIFO)) uut_f4 (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
        .resp_valid(v2), .resp_fault(f2), .resp_frame(fr2),
        .resp_evict_valid(e2), .resp_evict_page(p2), .fault_count(c2));

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state: timestamp per frame; victim = smallest stamp.
    int mnf  [3] = '{3, 3, 4};
    bit mlru [3] = '{1'b0, 1'b1, 1'b0};
    int mmax [3] = '{255, 255, 15};
    int mpg  [3][4];
    bit mused[3][4];
    int mst  [3][4];
    int mcnt [3];
    int tick;

    bit    e_fault [3];
    int    e_frame [3];
    bit    e_ev    [3];
    int    e_evp   [3];
    string e_tag   [3];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int m = 0; m < 3; m++) begin
            mcnt[m] = 0;
            for (int i = 0; i < 4; i++) begin
                mused[m][i] = 1'b0; mpg[m][i] = 0; mst[m][i] = 0;
            end
        end
        tick = 1;
    endtask

    task automatic model_step(input int m, input int page);
        int hit_at = -1;
        int free_at = -1;
        int vict = 0;
        for (int i = mnf[m] - 1; i >= 0; i--) begin
            if (mused[m][i] && mpg[m][i] == page) hit_at = i;
            if (!mused[m][i]) free_at = i;
        end
        if (hit_at >= 0) begin
            e_fault[m] = 1'b0; e_frame[m] = hit_at; e_ev[m] = 1'b0; e_tag[m] = "R3";
            if (mlru[m]) mst[m][hit_at] = tick;
        end else begin
            e_fault[m] = 1'b1;
            if (mcnt[m] < mmax[m]) mcnt[m]++;
            if (free_at >= 0) begin
                vict = free_at; e_ev[m] = 1'b0; e_tag[m] = "R4";
            end else begin
                for (int i = 1; i < mnf[m]; i++)
                    if (mst[m][i] < mst[m][vict]) vict = i;
                e_ev[m] = 1'b1; e_evp[m] = mpg[m][vict];
                e_tag[m] = mlru[m] ? "R6" : "R5";
            end
            e_frame[m] = vict;
            mpg[m][vict] = page; mused[m][vict] = 1'b1; mst[m][vict] = tick;
        end
    endtask

    task automatic check_inst(input int m, input bit v, input bit f, input int fr,
                              input bit e, input int p, input int c);
        chk("R2", $sformatf("inst%0d resp_valid", m), v, 1);
        chk(e_tag[m], $sformatf("inst%0d fault", m), f, e_fault[m]);
        chk(e_tag[m], $sformatf("inst%0d frame", m), fr, e_frame[m]);
        chk("R8", $sformatf("inst%0d evict_valid", m), e, e_ev[m]);
        if (e_ev[m]) chk("R8", $sformatf("inst%0d evict_page", m), p, e_evp[m]);
        chk("R7", $sformatf("inst%0d fault_count", m), c, mcnt[m]);
    endtask

    // Present one reference (called at a falling edge) and check the response.
    task automatic apply_ref(input int page);
        for (int m = 0; m < 3; m++) model_step(m, page);
        tick++;
        ref_valid = 1'b1;
        ref_page  = 8'(page);
        @(posedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
        check_inst(0, v0, f0, int'(fr0), e0, int'(p0), int'(c0));
        check_inst(1, v1, f1, int'(fr1), e1, int'(p1), int'(c1));
        check_inst(2, v2, f2, int'(fr2), e2, int'(p2), int'(c2));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Scenario: reset state, then a reset in mid-run forgets residency.
    task automatic t_reset();
        do_reset();
        chk("R1", "resp_valid after reset", v0 | v1 | v2, 0);
        chk("R1", "fault_count after reset", int'(c0) + int'(c1) + int'(c2), 0);
        apply_ref(5);
        chk("R1", "first ref faults into frame 0", {f0, fr0}, 3'b100);
        apply_ref(6);
        do_reset();
        chk("R1", "count cleared by mid-run reset", int'(c1), 0);
        apply_ref(6);
        chk("R1", "previously resident page faults after reset", f1, 1);
        chk("R1", "refill starts at frame 0", int'(fr1), 0);
    endtask

    // Scenario: fill, hits on back-to-back strobes.
    task automatic t_fill_and_hit();
        do_reset();
        apply_ref(10); apply_ref(11); apply_ref(12);
        chk("R4", "third fill lands in frame 2", int'(fr0), 2);
        apply_ref(11);
        chk("R3", "hit on page 11 reports frame 1", {f0, fr0}, 3'b001);
        apply_ref(10); apply_ref(12);
    endtask

    // Scenario: idle cycles after a response keep all outputs.
    task automatic t_idle_hold();
        logic [7:0] keep_p;
        logic [1:0] keep_fr;
        do_reset();
        apply_ref(1); apply_ref(2); apply_ref(3); apply_ref(4);
        keep_p = p0; keep_fr = fr0;
        repeat (3) @(negedge clk);
        chk("R2", "resp_valid low while idle", v0 | v1 | v2, 0);
        chk("R11", "evict page held", int'(p0), int'(keep_p));
        chk("R11", "frame held", int'(fr0), int'(keep_fr));
        chk("R11", "fault and evict flags held", {f0, e0}, 2'b11);
        chk("R11", "count held", int'(c0), 4);
    endtask

    // Scenario: a hit on the oldest page separates the two policies.
    task automatic t_policy_split();
        do_reset();
        apply_ref(1); apply_ref(2); apply_ref(3); apply_ref(1); apply_ref(4);
        chk("R5", "FIFO evicts page 1 from frame 0", {int'(p0), int'(fr0)}, {32'd1, 32'd0});
        chk("R6", "LRU evicts page 2 from frame 1", {int'(p1), int'(fr1)}, {32'd2, 32'd1});
        apply_ref(1);
        chk("R5", "FIFO faults on page 1 again", f0, 1);
        chk("R6", "LRU keeps page 1 resident", f1, 0);
    endtask

    // Scenario: 22-reference string fault totals.
    task automatic t_ref_string();
        int s [22] = '{7,0,1,2,0,3,0,4,2,3,0,3,0,3,2,1,2,0,1,7,0,1};
        do_reset();
        foreach (s[i]) apply_ref(s[i]);
        chk("R9", "FIFO 3-frame fault total", int'(c0), 15);
        chk("R9", "LRU 3-frame fault total", int'(c1), 12);
    endtask

    // Scenario: more frames, more FIFO faults.
    task automatic t_belady();
        int s [12] = '{1,2,3,4,1,2,5,1,2,3,4,5};
        do_reset();
        foreach (s[i]) apply_ref(s[i]);
        chk("R10", "FIFO 3-frame faults", int'(c0), 9);
        chk("R10", "FIFO 4-frame faults", int'(c2), 10);
    endtask

    // Scenario: counter saturation on the narrow instance.
    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 20; i++) apply_ref(100 + i);
        chk("R7", "4-bit counter saturates at 15", int'(c2), 15);
        chk("R7", "8-bit counter reaches 20", int'(c0), 20);
    endtask

    initial begin
        model_clear();
        t_reset();
        t_fill_and_hit();
        t_idle_hold();
        t_policy_split();
        t_ref_string();
        t_belady();
        t_saturate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule